// File: doc/BRIEF.md
# Receive Bit-Slip Alignment Controller

This block sits behind a deserializer and realigns a stream of parallel receive words one bit at a time. Each accepted input word is joined with the word accepted before it. The output word is a W-bit window taken from that pair at the current bit offset, so a character that straddles two input words can be moved onto the word boundary. The offset changes by one position for each slip. In the manual modes, software logic asks for a slip with a one-cycle pulse on `slide_i`. In the automatic mode, the block finds the comma itself and slips until the comma sits at bit 0. After each slip a settling window of `wait_cfg_i` cycles blocks further slips.

Both data sides use valid/ready handshakes. An input word is taken on a clock edge where `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid_o` is high and `out_ready_i` is low, the output word is held unchanged and no new input is accepted. The control pins (`mode_i`, `wait_cfg_i`, `slide_i`) and the status pins (`aligned_o`, `offset_o`) are plain signals.

Top module: `rx_bitslip_align`

## Requirements
- R1: Word bit 0 is the earliest bit on the line. For accepted word n at offset k, the output is bits k..k+W-1, counted from the most recent end, of the concatenation {word n, word n-1}; that is, `({cur, prev} >> (W-k))[W-1:0]`. It appears on the edge that accepts word n.
- R2: `in_ready_o` equals `!out_valid_o || out_ready_i`. While the output is stalled, `out_data_o` and `out_valid_o` stay unchanged.
- R3: In mode 1 (left), each accepted slide pulse raises the offset by one. The offset wraps from W-1 to 0.
- R4: In mode 2 (right), each accepted slide pulse lowers the offset by one. The offset wraps from 0 to W-1.
- R5: In mode 0 (off), the offset is forced to 0 one cycle later, the output equals the current input word, and slide pulses have no effect.
- R6: Every slip loads a settling counter with `wait_cfg_i`. A manual pulse seen while that counter is non-zero is dropped and is not queued.
- R7: In mode 3 (auto), `slide_i` is ignored. The block slips by one left step at a time until a comma sits at output bits 9:0, then raises `aligned_o` and stops slipping.
- R8: In auto mode with words flowing every cycle, consecutive automatic slips are max(2, `wait_cfg_i`+1) cycles apart.
- R9: The comma is 10'h17C or 10'h283, compared against bits 9:0 of the window. `aligned_o` rises on the cycle after an output word carrying a comma at bit 0 is evaluated. Any slip clears it.
- R10: In auto mode, a comma found at output positions 1..W-10 clears `aligned_o` and restarts the search from the current offset.
- R11: Reset clears the offset, `aligned_o`, `out_valid_o` and the history word. The history word is treated as zero until the first word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 off, 1 left, 2 right, 3 auto |
| wait_cfg_i | input | 4 | Settling cycles after a slip (0..15) |
| slide_i | input | 1 | One-cycle manual slip request |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word can be taken |
| in_data_i | input | W | Input parallel word, bit 0 earliest |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream accepts the output word |
| out_data_o | output | W | Realigned output word |
| aligned_o | output | 1 | Comma seen at output bit 0 |
| offset_o | output | $clog2(W) | Current bit offset |

## Verification
The hardest state to reach is losing lock in auto mode. The block must first lock at one offset. The incoming comma phase must then move so that the comma lands at a visible non-zero position in the output window, rather than straddling two words, where it would stay unseen. The bench first drives a stream with the comma at bit 5 until the block locks at offset 15. It then moves the stream to bit 8. At offset 15 that puts the comma at output position 3, which forces a drop of `aligned_o` and a fresh search ending at offset 12. The bench also times the gaps between slips during both searches to confirm the settling window.

// File: rtl/rx_bitslip_pkg.sv
package rx_bitslip_pkg;

  typedef enum logic [1:0] {
    SLIP_OFF   = 2'd0,
    SLIP_LEFT  = 2'd1,
    SLIP_RIGHT = 2'd2,
    SLIP_AUTO  = 2'd3
  } slip_mode_e;

  localparam int CHAR_W = 10;
  localparam logic [CHAR_W-1:0] COMMA_MINUS = 10'h17C;
  localparam logic [CHAR_W-1:0] COMMA_PLUS  = 10'h283;

  function automatic logic is_comma(input logic [CHAR_W-1:0] chr);
    return (chr == COMMA_MINUS) || (chr == COMMA_PLUS);
  endfunction

endpackage

// File: rtl/rx_bitslip_window.sv
module rx_bitslip_window #(
  parameter int W  = 20,
  parameter int OW = $clog2(W)
) (
  input  logic [W-1:0]  cur_i,
  input  logic [W-1:0]  prev_i,
  input  logic [OW-1:0] offset_i,
  output logic [W-1:0]  word_o
);

  localparam int CAT_W = 2 * W;

  logic [CAT_W-1:0] cat;
  logic [W-1:0]     cand [W];

  assign cat = {cur_i, prev_i};

  // one candidate per offset: window starts k bits before the current word
  for (genvar k = 0; k < W; k++) begin : g_cand
    assign cand[k] = cat[W-k +: W];
  end

  always_comb begin
    word_o = cand[0];
    for (int k = 1; k < W; k++) begin
      if (offset_i == OW'(k)) word_o = cand[k];
    end
  end

endmodule

// File: rtl/rx_bitslip_comma_scan.sv
module rx_bitslip_comma_scan
  import rx_bitslip_pkg::*;
#(
  parameter int W = 20
) (
  input  logic [W-1:0] word_i,
  output logic         at_zero_o,
  output logic         elsewhere_o
);

  localparam int NPOS = W - CHAR_W + 1;

  logic [NPOS-1:0] hit;

  for (genvar p = 0; p < NPOS; p++) begin : g_pos
    assign hit[p] = is_comma(word_i[p +: CHAR_W]);
  end

  assign at_zero_o = hit[0];

  if (NPOS > 1) begin : g_other
    assign elsewhere_o = |hit[NPOS-1:1];
  end else begin : g_none
    assign elsewhere_o = 1'b0;
  end

endmodule

// File: rtl/rx_bitslip_pipe.sv
module rx_bitslip_pipe #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  input  logic [W-1:0] win_word_i,
  output logic [W-1:0] hist_o,
  output logic         load_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);

  logic [W-1:0] hist_q;
  logic [W-1:0] out_q;
  logic         vld_q;

  assign in_ready_o = !vld_q || out_ready_i;
  assign load_o     = in_valid_i && in_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (load_o) begin
        hist_q <= in_data_i;
        out_q  <= win_word_i;
        vld_q  <= 1'b1;
      end else if (out_ready_i) begin
        vld_q  <= 1'b0;
      end
    end
  end

  assign hist_o      = hist_q;
  assign out_data_o  = out_q;
  assign out_valid_o = vld_q;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(out_q)));

endmodule

// File: rtl/rx_bitslip_ctrl.sv
module rx_bitslip_ctrl
  import rx_bitslip_pkg::*;
#(
  parameter int W      = 20,
  parameter int OW     = $clog2(W),
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slip_mode_e        mode_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic              slide_i,
  input  logic              load_i,
  input  logic              comma_zero_i,
  input  logic              comma_else_i,
  output logic [OW-1:0]     offset_o,
  output logic              aligned_o
);

  localparam logic [OW-1:0] LAST = OW'(W - 1);

  logic [OW-1:0]     offset_q;
  logic [OW-1:0]     offset_nxt;
  logic [WAIT_W-1:0] settle_q;
  logic              pend_q;
  logic              aligned_q;
  logic              manual;
  logic              settling;
  logic              man_slip;
  logic              auto_slip;
  logic              slip;
  logic              eval;

  assign manual   = (mode_i == SLIP_LEFT) || (mode_i == SLIP_RIGHT);
  assign settling = (settle_q != '0);
  assign eval     = pend_q && !settling;
  assign man_slip = manual && slide_i && !settling;
  assign auto_slip = (mode_i == SLIP_AUTO) && eval && !comma_zero_i &&
                     (comma_else_i || !aligned_q);
  assign slip     = man_slip || auto_slip;

  always_comb begin
    if (mode_i == SLIP_RIGHT) begin
      offset_nxt = (offset_q == '0) ? LAST : offset_q - 1'b1;
    end else begin
      offset_nxt = (offset_q == LAST) ? '0 : offset_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q  <= '0;
      settle_q  <= '0;
      pend_q    <= 1'b0;
      aligned_q <= 1'b0;
    end else begin
      if (mode_i == SLIP_OFF) offset_q <= '0;
      else if (slip)          offset_q <= offset_nxt;

      if (slip)          settle_q <= wait_cfg_i;
      else if (settling) settle_q <= settle_q - 1'b1;

      // a word loaded on the slip edge was built with the old offset
      if (slip)        pend_q <= 1'b0;
      else if (load_i) pend_q <= 1'b1;
      else if (eval)   pend_q <= 1'b0;

      if (slip)                                        aligned_q <= 1'b0;
      else if (eval && comma_zero_i)                   aligned_q <= 1'b1;
      else if (eval && comma_else_i && mode_i == SLIP_AUTO) aligned_q <= 1'b0;
    end
  end

  assign offset_o  = offset_q;
  assign aligned_o = aligned_q;

  // R3
  left_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SLIP_LEFT && slide_i && settle_q == '0) |=>
      (offset_q == (($past(offset_q) == LAST) ? '0 : $past(offset_q) + 1'b1)));

  // R5
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SLIP_OFF) |=> (offset_q == '0));

  // R6
  settle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manual && slide_i && settle_q != '0) |=> $stable(offset_q));

  // R7
  auto_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SLIP_AUTO && !pend_q) |=> $stable(offset_q));

  // R8
  auto_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SLIP_AUTO && settle_q != '0) |=> $stable(offset_q));

endmodule

// File: rtl/rx_bitslip_align.sv
module rx_bitslip_align
  import rx_bitslip_pkg::*;
#(
  parameter int W      = 20,
  parameter int WAIT_W = 4,
  localparam int OW    = $clog2(W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  input  logic              slide_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [W-1:0]      in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [W-1:0]      out_data_o,
  output logic              aligned_o,
  output logic [OW-1:0]     offset_o
);

  slip_mode_e   mode;
  logic [W-1:0] hist;
  logic [W-1:0] win_word;
  logic         load;
  logic         comma_zero;
  logic         comma_else;

  assign mode = slip_mode_e'(mode_i);

  rx_bitslip_window #(.W(W), .OW(OW)) u_window (
    .cur_i    (in_data_i),
    .prev_i   (hist),
    .offset_i (offset_o),
    .word_o   (win_word)
  );

  rx_bitslip_pipe #(.W(W)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .in_data_i   (in_data_i),
    .win_word_i  (win_word),
    .hist_o      (hist),
    .load_o      (load),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o)
  );

  rx_bitslip_comma_scan #(.W(W)) u_scan (
    .word_i      (out_data_o),
    .at_zero_o   (comma_zero),
    .elsewhere_o (comma_else)
  );

  rx_bitslip_ctrl #(.W(W), .OW(OW), .WAIT_W(WAIT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .wait_cfg_i   (wait_cfg_i),
    .slide_i      (slide_i),
    .load_i       (load),
    .comma_zero_i (comma_zero),
    .comma_else_i (comma_else),
    .offset_o     (offset_o),
    .aligned_o    (aligned_o)
  );

endmodule

// File: tb/rx_bitslip_align_bench.sv
module rx_bitslip_align_bench;

  localparam int W = 20;
  localparam int OW = $clog2(W);
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] K_MINUS = 10'h17C;
  localparam logic [9:0] K_PLUS  = 10'h283;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [3:0]    wait_cfg = 4'd0;
  logic          slide = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [W-1:0]  out_data;
  logic          aligned;
  logic [OW-1:0] offset;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] prev_w = '0;
  int exp_k = 0;

  rx_bitslip_align #(.W(W)) u_rx_bitslip_align (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .wait_cfg_i(wait_cfg),
    .slide_i(slide), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .aligned_o(aligned), .offset_o(offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] ref_win(logic [W-1:0] cur, logic [W-1:0] prev, int k);
    logic [2*W-1:0] cat;
    cat = {cur, prev};
    return cat[W-k +: W];
  endfunction

  task automatic expect_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic push(logic [W-1:0] w, string req);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    @(negedge clk); in_valid = 1'b0;
    expect_eq(req, "out_valid", 32'(out_valid), 32'd1);
    expect_eq(req, "out_data", 32'(out_data), 32'(ref_win(w, prev_w, exp_k)));
    prev_w = w;
  endtask

  task automatic pulse();
    @(negedge clk); slide = 1'b1;
    @(negedge clk); slide = 1'b0;
  endtask

  task automatic t_reset();
    expect_eq("R11", "offset", 32'(offset), 32'd0);
    expect_eq("R11", "aligned", 32'(aligned), 32'd0);
    expect_eq("R11", "out_valid", 32'(out_valid), 32'd0);
    expect_eq("R2", "in_ready", 32'(in_ready), 32'd1);
    mode = 2'd1;
    pulse(); exp_k = 1;
    expect_eq("R3", "offset", 32'(offset), 32'd1);
    // history must be zero: bit 0 of the window comes from it
    push({W{1'b1}}, "R11");
  endtask

  task automatic t_off();
    mode = 2'd0;
    @(negedge clk); exp_k = 0;
    expect_eq("R5", "offset", 32'(offset), 32'd0);
    pulse();
    expect_eq("R5", "offset after pulse", 32'(offset), 32'd0);
    push(20'hA5C31, "R5");
    push(20'h1F0E7, "R1");
  endtask

  task automatic t_left();
    mode = 2'd1; wait_cfg = 4'd0;
    push({10'd0, K_PLUS}, "R9");
    @(negedge clk);
    expect_eq("R9", "aligned on comma", 32'(aligned), 32'd1);
    pulse(); exp_k = 1;
    expect_eq("R3", "offset", 32'(offset), 32'd1);
    expect_eq("R9", "aligned cleared by slip", 32'(aligned), 32'd0);
    push(20'h3C96D, "R1");
    push(20'h82F14, "R1");
    pulse(); pulse(); exp_k = 3;
    push(20'h5E0B9, "R3");
    for (int i = 0; i < W - 3; i++) pulse();
    exp_k = 0;
    expect_eq("R3", "wrap to 0", 32'(offset), 32'd0);
  endtask

  task automatic t_right();
    mode = 2'd2;
    pulse(); exp_k = W - 1;
    expect_eq("R4", "wrap to W-1", 32'(offset), 32'(W - 1));
    push(20'h7D2A4, "R4");
    push(20'h0C3F8, "R1");
    pulse(); exp_k = W - 2;
    expect_eq("R4", "step down", 32'(offset), 32'(W - 2));
    push(20'hE6157, "R4");
  endtask

  task automatic t_settle();
    int start;
    mode = 2'd1; wait_cfg = 4'd3;
    start = int'(offset);
    @(negedge clk); slide = 1'b1;
    @(negedge clk); slide = 1'b1;
    @(negedge clk); slide = 1'b0;
    expect_eq("R6", "second pulse dropped", 32'(offset), 32'((start + 1) % W));
    repeat (4) @(negedge clk);
    expect_eq("R6", "no queued slip", 32'(offset), 32'((start + 1) % W));
    pulse();
    expect_eq("R6", "pulse after settle", 32'(offset), 32'((start + 2) % W));
    exp_k = (start + 2) % W;
    wait_cfg = 4'd0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_stall();
    logic [W-1:0] held;
    push(20'h4B6E2, "R2");
    held = out_data;
    out_ready = 1'b0; in_valid = 1'b1; in_data = 20'h9A1C5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      expect_eq("R2", "in_ready low", 32'(in_ready), 32'd0);
      expect_eq("R2", "held data", 32'(out_data), 32'(held));
    end
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    expect_eq("R2", "released word", 32'(out_data), 32'(ref_win(20'h9A1C5, prev_w, exp_k)));
    prev_w = 20'h9A1C5;
  endtask

  task automatic t_auto(int phase, int wt, bit from_zero, int exp_final, bit want_drop, string req);
    int last_off, last_t, n_gap, bad_gap, exp_gap;
    bit dropped;
    exp_gap = (wt + 1 > 2) ? wt + 1 : 2;
    wait_cfg = 4'(wt);
    if (from_zero) begin
      mode = 2'd0; @(negedge clk);
    end
    mode = 2'd3; slide = 1'b1;      // external pulses must be ignored
    last_off = int'(offset); last_t = -1; n_gap = 0; bad_gap = 0; dropped = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = W'({10'd0, K_MINUS}) << phase;
      if (!aligned) dropped = 1;
      if (int'(offset) != last_off) begin
        if (last_t >= 0) begin
          n_gap++;
          if (t - last_t != exp_gap) bad_gap++;
        end
        last_t = t; last_off = int'(offset);
      end
    end
    in_valid = 1'b0; slide = 1'b0;
    @(negedge clk);
    expect_eq(req, "final offset", 32'(offset), 32'(exp_final));
    expect_eq("R7", "aligned after search", 32'(aligned), 32'd1);
    expect_eq("R8", "slip spacing violations", 32'(bad_gap), 32'd0);
    expect_eq("R8", "spacing measured", 32'(n_gap > 2), 32'd1);
    if (want_drop) expect_eq("R10", "lock lost", 32'(dropped), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_left();
    t_right();
    t_settle();
    t_stall();
    t_auto(5, 7, 1'b1, 15, 1'b0, "R7");
    t_auto(8, 7, 1'b0, 12, 1'b1, "R10");
    t_auto(5, 0, 1'b1, 15, 1'b0, "R8");
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

endmodule